// File: doc/BRIEF.md
# PPS-Aligned Ping-Pong Sample Writer

This block sits at the end of a decimating receive chain. It takes complex baseband samples, each a 32-bit in-phase value and a 32-bit quadrature value qualified by a valid strobe, and writes them as 64-bit words into an external dual-port RAM. The RAM is split into two equal halves. In the default setting each half holds 10000 words, one second of data at 10 kS/s, so the whole buffer is 20000 words (160000 bytes) and fits in a 256 KB address window.

Writing is locked to an external one-pulse-per-second reference. The reference is synchronised and edge-detected. The first edge after reset arms the writer at word 0. Every later edge switches to the other half and restarts at that half's base, so the write address returns to zero on every second edge. The half in use is driven out as a square wave at half the PPS rate. That signal also serves as the status bit that tells software which half is being filled. A per-half completion flag shows when a half holds a full second of data. Software then reads the other half through its own port while the current half is being written.

Top module: `pps_pingpong_writer`

## Requirements
- R1: Each written word carries the quadrature sample in bits 63:32 and the in-phase sample in bits 31:0.
- R2: After reset `ram_we`, `ram_addr`, `ram_wdata`, `half_pps` and `half_done` are all zero. No word is written until the first PPS rising edge has been seen.
- R3: `pps_in` passes through a two-flop synchroniser. A rising edge takes effect on the third rising clock edge at which `pps_in` is sampled high. A pulse of any width counts exactly once.
- R4: The first PPS edge after reset selects half 0 (`half_pps` = 0) and word address 0.
- R5: Every later PPS edge inverts `half_pps`. Half 1 starts at address HALF_DEPTH and half 0 starts at address 0, so the address returns to zero on every second edge.
- R6: The address advances by one only for each accepted valid sample. `ram_we` is asserted for one cycle, one clock after the sample is presented, with the address and data of that sample.
- R7: Once HALF_DEPTH words have been written into the current half, further samples are dropped until the next PPS edge. Writing never continues past the end of the half or wraps around.
- R8: `half_done[h]` rises in the same cycle as the write of the last word of half h. It clears on the PPS edge that starts writing half h again.
- R9: A sample presented in the same cycle that a PPS edge takes effect is written at the new half's base address.
- R10: Every write lands inside the half that `half_pps` names: from `half_pps`·HALF_DEPTH up to but not including (`half_pps`+1)·HALF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 32 | In-phase sample |
| smp_q | input | 32 | Quadrature sample |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address, ADDR_W = clog2(2·HALF_DEPTH) |
| ram_wdata | output | 64 | RAM write word {Q, I} |
| half_pps | output | 1 | Half-rate PPS square wave; status of the half being written |
| half_done | output | 2 | Per-half completion flags |

## Verification
The bench runs the writer with an 8-word half and sweeps the sample density (every cycle, every second cycle, every third cycle) against PPS pulses 1 to 4 cycles wide. This separates address advance on valid samples from advance on cycles, and shows that a wide pulse counts only once. Each phase lasts longer than one half, so the half overflows and the dropped samples and held address show up. Runs with the PPS edge placed mid-stream show whether the realignment to the base and the same-cycle sample land correctly. A long stream before any PPS edge shows whether writes stay suppressed until the writer is armed. A cycle-accurate arithmetic model predicts every port on every cycle.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    localparam int SMP_W  = 32;
    localparam int WORD_W = 2 * SMP_W;

    // Packed RAM word: quadrature on top, in-phase below.
    typedef struct packed {
        logic [SMP_W-1:0] q;
        logic [SMP_W-1:0] i;
    } iq_word_t;

    // Which half of the ping-pong buffer is being filled.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_t;

    function automatic iq_word_t pack_iq(input logic [SMP_W-1:0] i_s,
                                         input logic [SMP_W-1:0] q_s);
        iq_word_t w;
        w.i = i_s;
        w.q = q_s;
        return w;
    endfunction

    function automatic int half_base(input half_t h, input int half_depth);
        return (h == HALF_HIGH) ? half_depth : 0;
    endfunction

endpackage

// File: rtl/ppw_pps_edge.sv
module ppw_pps_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_async,
    output logic pps_edge
);

    // Stages 0..SYNC_STAGES-1 synchronise; the last stage delays for edge detection.
    logic [SYNC_STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], pps_async};
        end
    end

    assign pps_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pps_edge |=> !pps_edge); // R3

endmodule

// File: rtl/ppw_sequencer.sv
module ppw_sequencer
    import ppw_pkg::*;
#(
    parameter int HALF_DEPTH = 10000,   // must be at least 2
    parameter int ADDR_W     = $clog2(2 * HALF_DEPTH),
    localparam int CNT_W     = $clog2(HALF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_edge,
    input  logic              smp_valid,
    output logic              fire,
    output logic [ADDR_W-1:0] wr_addr,
    output half_t             half_q,
    output logic [1:0]        done_q,
    output logic              armed_q
);

    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(HALF_DEPTH);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(HALF_DEPTH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] nxt_cnt;
    half_t            nxt_half;
    logic             nxt_armed;
    logic             room;
    logic [1:0]       done_d;
    logic [ADDR_W-1:0] base;

    always_comb begin
        nxt_armed = armed_q | pps_edge;
        if (pps_edge) begin
            nxt_half = armed_q ? half_t'(~half_q) : HALF_LOW;
            cur_cnt  = '0;
        end else begin
            nxt_half = half_q;
            cur_cnt  = cnt_q;
        end
        room    = (cur_cnt < CNT_FULL);
        fire    = nxt_armed & smp_valid & room;
        base    = ADDR_W'(half_base(nxt_half, HALF_DEPTH));
        wr_addr = base + ADDR_W'(cur_cnt);
        nxt_cnt = fire ? cur_cnt + 1'b1 : cur_cnt;

        done_d = done_q;
        if (pps_edge) begin
            done_d[nxt_half] = 1'b0;
        end
        if (fire && (cur_cnt == CNT_LAST)) begin
            done_d[nxt_half] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            half_q  <= HALF_LOW;
            cnt_q   <= '0;
            done_q  <= '0;
        end else begin
            armed_q <= nxt_armed;
            half_q  <= nxt_half;
            cnt_q   <= nxt_cnt;
            done_q  <= done_d;
        end
    end

    AST_HALF_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$past(pps_edge) |-> $stable(half_q)); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_FULL) && !pps_edge |=> (cnt_q == CNT_FULL)); // R7

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        pps_edge |=> !done_q[half_q]); // R8

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL); // R7

endmodule

// File: rtl/ppw_write_port.sv
module ppw_write_port
    import ppw_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic [SMP_W-1:0]  smp_q,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output iq_word_t          ram_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_word <= '0;
        end else begin
            ram_we <= fire;
            if (fire) begin
                ram_addr <= wr_addr;
                ram_word <= pack_iq(smp_i, smp_q);
            end
        end
    end

    AST_WORD_LATCHED: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_word.i == $past(smp_i)) && (ram_word.q == $past(smp_q))); // R1

endmodule

// File: rtl/pps_pingpong_writer.sv
module pps_pingpong_writer
    import ppw_pkg::*;
#(
    parameter int  HALF_DEPTH  = 10000,
    parameter int  SYNC_STAGES = 2,
    localparam int DEPTH       = 2 * HALF_DEPTH,
    localparam int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [31:0]       smp_i,
    input  logic [31:0]       smp_q,
    input  logic              pps_in,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [63:0]       ram_wdata,
    output logic              half_pps,
    output logic [1:0]        half_done
);

    logic              pps_edge;
    logic              fire;
    logic [ADDR_W-1:0] wr_addr;
    half_t             half_q;
    logic [1:0]        done_q;
    logic              armed_q;
    iq_word_t          ram_word;

    ppw_pps_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pps_async (pps_in),
        .pps_edge  (pps_edge)
    );

    ppw_sequencer #(
        .HALF_DEPTH (HALF_DEPTH),
        .ADDR_W     (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pps_edge  (pps_edge),
        .smp_valid (smp_valid),
        .fire      (fire),
        .wr_addr   (wr_addr),
        .half_q    (half_q),
        .done_q    (done_q),
        .armed_q   (armed_q)
    );

    ppw_write_port #(
        .ADDR_W (ADDR_W)
    ) u_wr (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .wr_addr  (wr_addr),
        .smp_i    (smp_i),
        .smp_q    (smp_q),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_word (ram_word)
    );

    assign ram_wdata = ram_word;
    assign half_pps  = half_q;
    assign half_done = done_q;

    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(smp_valid)); // R6

    AST_WE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> armed_q); // R2

    AST_ADDR_IN_HALF: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (half_pps ? (int'(ram_addr) >= HALF_DEPTH && int'(ram_addr) < DEPTH)
                             : (int'(ram_addr) < HALF_DEPTH))); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        ram_we && $past(ram_we) && $stable(half_pps) && !$past(pps_edge)
        |-> ram_addr == $past(ram_addr) + 1'b1); // R6

endmodule

// File: tb/pps_pingpong_writer_test.sv
module pps_pingpong_writer_test;

    localparam int HALF = 8;
    localparam int AW   = $clog2(2 * HALF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [31:0]   smp_i = '0;
    logic [31:0]   smp_q = '0;
    logic          pps_in = 1'b0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [63:0]   ram_wdata;
    logic          half_pps;
    logic [1:0]    half_done;

    int n_tests = 0;
    int n_fail  = 0;
    int seq     = 0;
    bit summary_done = 0;

    // Reference model state
    bit         m_s1, m_s2, m_s3;
    bit         m_armed, m_half;
    int         m_cnt;
    bit [1:0]   m_done;
    bit         e_we;
    int         e_addr;
    logic [63:0] e_data;

    always #4 clk = ~clk;

    pps_pingpong_writer #(.HALF_DEPTH(HALF)) uut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_i     (smp_i),
        .smp_q     (smp_q),
        .pps_in    (pps_in),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .half_pps  (half_pps),
        .half_done (half_done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit p);
        bit edge_now;
        @(negedge clk);
        smp_valid = v;
        pps_in    = p;
        smp_i     = 32'h1000_0000 + 32'(seq);
        smp_q     = 32'hC000_0000 ^ (32'(seq) * 32'd7);
        seq++;
        @(posedge clk);
        // model: two synchroniser flops plus one delay flop for the edge
        edge_now = m_s2 & ~m_s3;
        m_s3 = m_s2;
        m_s2 = m_s1;
        m_s1 = p;
        if (edge_now) begin
            m_half  = m_armed ? ~m_half : 1'b0;
            m_armed = 1'b1;
            m_cnt   = 0;
            m_done[m_half] = 1'b0;
        end
        e_we = m_armed && v && (m_cnt < HALF);
        if (e_we) begin
            e_addr = (m_half ? HALF : 0) + m_cnt;
            e_data = {smp_q, smp_i};
            m_cnt++;
            if (m_cnt == HALF) m_done[m_half] = 1'b1;
        end
        #2;
        chk("R2 R3 R6 R7 ram_we", longint'(ram_we), longint'(e_we));
        if (e_we && ram_we) begin
            chk("R4 R5 R9 ram_addr", longint'(ram_addr), longint'(e_addr));
            chk("R1 ram_wdata", longint'(ram_wdata), longint'(e_data));
            chk("R10 addr in half", longint'(int'(ram_addr) / HALF), longint'(half_pps));
        end
        chk("R5 half_pps", longint'(half_pps), longint'(m_half));
        chk("R8 half_done", longint'(half_done), longint'(m_done));
    endtask

    task automatic phase(input int ncyc, input int vmod, input int pps_at, input int pps_w);
        for (int c = 0; c < ncyc; c++) begin
            step((c % vmod) == 0, (c >= pps_at) && (c < pps_at + pps_w));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R2 reset ram_we", longint'(ram_we), 0);
        chk("R2 reset ram_addr", longint'(ram_addr), 0);
        chk("R2 reset ram_wdata", longint'(ram_wdata), 0);
        chk("R2 reset half_pps", longint'(half_pps), 0);
        chk("R2 reset half_done", longint'(half_done), 0);

        // R2: a long valid stream before any PPS edge writes nothing
        phase(3 * HALF, 1, 1000, 0);
        // R4: first edge arms at half 0, address 0; R7: overflow of that half
        phase(2 * HALF + 6, 1, 0, 1);
        // R3: sweep of pulse widths against sample densities, full and overflowing halves
        for (int w = 1; w <= 4; w++) begin
            for (int m = 1; m <= 3; m++) begin
                phase(m * HALF + 8, m, 0, w);
            end
        end
        // R9: edges landing mid-stream and early, before a half is full
        for (int at = 1; at <= 5; at++) begin
            phase(HALF + 4, 1, at, 2);
            phase(HALF / 2 + 4, 2, 0, 1);
        end
        // Long pulse covering many cycles counts once (R3)
        phase(3 * HALF, 1, 0, 2 * HALF);

        if (!summary_done) begin
            summary_done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!summary_done) begin
            summary_done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

endmodule